// File: doc/BRIEF.md
# SRAM Power-Up Readiness and Clock-Mode Sequencer

This block tracks the start-up conditions a synchronous SRAM-style device must meet before its output drivers count as calibrated and its output timing as locked. It runs on a free-running reference clock. Each rising edge of the device input clock reaches it as a one-cycle strobe, `k_tick_i`, in the reference domain, with `rd_i` marking whether that device cycle is a read.

Three flags come out of it. A calibration counter advances on each non-read device cycle. A relock counter advances on every device cycle and restarts whenever a watchdog finds that the device clock has stopped. A mode flag records at power-up whether both output-clock inputs were held high, which selects single-clock operation. A fourth flag, `upd_ok_o`, marks the reference cycle after each device cycle that left the outputs idle. Impedance refresh may take place only in such a cycle. The analog impedance circuit and the delay line itself are outside the block.

Top module: `sram_rdy_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after its release, `imp_ready_o`, `dll_locked_o` and `upd_ok_o` are 0.
- R2: `imp_ready_o` goes to 1 on the clock edge that samples the CAL_CYCLES-th non-read device cycle after reset. A non-read device cycle is `k_tick_i`=1 with `rd_i`=0. The flag stays 1 until the next reset.
- R3: A device cycle with `rd_i`=1 does not advance calibration. It only pauses the count. Reads after `imp_ready_o` is set do not clear it.
- R4: `upd_ok_o` is 1 for exactly one reference cycle, after the edge that samples a non-read device cycle. It is 0 after a read device cycle and after a reference cycle with no device cycle.
- R5: `dll_locked_o` goes to 1 on the edge that samples the LOCK_CYCLES-th device cycle after reset, whatever `rd_i` is.
- R6: After TIMEOUT consecutive reference cycles with no `k_tick_i`, the clock counts as lost. On each following edge with no tick, the relock count is cleared and `dll_locked_o` drops to 0. The first returning tick counts as relock cycle 1.
- R7: `single_clk_o` takes the value of `c_i` AND `cb_i` as sampled on the first clock edge after reset release. Later changes on `c_i` or `cb_i` have no effect on it.
- R8: A new reset clears the counters and flags and samples the clock mode again.
- R9: Gaps between device cycles that are shorter than TIMEOUT reference cycles do not disturb the lock or the relock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| k_tick_i | input | 1 | One-cycle strobe per device input-clock rising edge |
| rd_i | input | 1 | Current device cycle is a read (valid with k_tick_i) |
| c_i | input | 1 | Output-clock input, true phase |
| cb_i | input | 1 | Output-clock input, complement phase |
| imp_ready_o | output | 1 | Impedance calibration complete |
| dll_locked_o | output | 1 | Delay-locked loop considered locked |
| upd_ok_o | output | 1 | Impedance update permitted this cycle |
| single_clk_o | output | 1 | Single-clock mode latched at power-up |

## Verification
The assertions assume that `k_tick_i` is already a clean single-cycle strobe in the reference domain. They also assume that `rd_i` is looked at only when a tick is present, and that `c_i`/`cb_i` settle before reset is released. The bench drives every input on the falling edge of the reference clock and changes `c_i`/`cb_i` only while reset is held or after the mode has been sampled. It issues at most one tick per reference cycle. Its stimulus keeps tick gaps both below and above the timeout, so that loss and recovery are both exercised.

// File: rtl/sram_rdy_pkg.sv
package sram_rdy_pkg;
  typedef enum logic {
    CLK_DUAL   = 1'b0,
    CLK_SINGLE = 1'b1
  } clk_mode_e;

  function automatic int cnt_w(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/sram_rdy_satcnt.sv
module sram_rdy_satcnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int W = sram_rdy_pkg::cnt_w(LIMIT);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (en_i && cnt_q != LIM_V)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM_V);

  // once reached, only clear may take it away (R3 for calibration, R5 for lock)
  assert_done_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o);

  // completion only follows a counted cycle
  assert_done_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(en_i));
endmodule

// File: rtl/sram_rdy_wdog.sv
module sram_rdy_wdog #(
  parameter int TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic lost_o
);
  localparam int W = sram_rdy_pkg::cnt_w(TIMEOUT);
  localparam logic [W-1:0] TO_V = W'(TIMEOUT);

  logic [W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idle_q <= '0;
    else if (tick_i)          idle_q <= '0;
    else if (idle_q != TO_V)  idle_q <= idle_q + 1'b1;
  end

  assign lost_o = (idle_q == TO_V);

  assert_tick_rearms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !lost_o);
endmodule

// File: rtl/sram_rdy_mode.sv
module sram_rdy_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic c_i,
  input  logic cb_i,
  output logic single_o
);
  import sram_rdy_pkg::*;

  clk_mode_e mode_q;
  logic      sampled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= CLK_DUAL;
      sampled_q <= 1'b0;
    end else if (!sampled_q) begin
      mode_q    <= (c_i && cb_i) ? CLK_SINGLE : CLK_DUAL;
      sampled_q <= 1'b1;
    end
  end

  assign single_o = (mode_q == CLK_SINGLE);

  assert_mode_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampled_q |=> $stable(single_o));
endmodule

// File: rtl/sram_rdy_seq.sv
module sram_rdy_seq #(
  parameter int CAL_CYCLES  = 1024,
  parameter int LOCK_CYCLES = 1024,
  parameter int TIMEOUT     = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic k_tick_i,
  input  logic rd_i,
  input  logic c_i,
  input  logic cb_i,
  output logic imp_ready_o,
  output logic dll_locked_o,
  output logic upd_ok_o,
  output logic single_clk_o
);
  logic non_rd;
  logic lost;
  logic upd_q;

  assign non_rd = k_tick_i && !rd_i;

  sram_rdy_satcnt #(.LIMIT(CAL_CYCLES)) u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (non_rd),
    .clr_i  (1'b0),
    .done_o (imp_ready_o)
  );

  sram_rdy_wdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (k_tick_i),
    .lost_o (lost)
  );

  sram_rdy_satcnt #(.LIMIT(LOCK_CYCLES)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (k_tick_i),
    .clr_i  (lost && !k_tick_i),
    .done_o (dll_locked_o)
  );

  sram_rdy_mode u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .c_i      (c_i),
    .cb_i     (cb_i),
    .single_o (single_clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= non_rd;
  end

  assign upd_ok_o = upd_q;

  assert_no_upd_after_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_tick_i && rd_i |=> !upd_ok_o);

  assert_no_upd_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !k_tick_i |=> !upd_ok_o);

  assert_loss_unlocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost && !k_tick_i |=> !dll_locked_o);

  assert_read_keeps_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imp_ready_o |=> imp_ready_o);
endmodule

// File: tb/sram_rdy_seq_tb.sv
module sram_rdy_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CAL = 8;
  localparam int LCK = 6;
  localparam int TO  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic k_tick_i = 1'b0;
  logic rd_i = 1'b0;
  logic c_i = 1'b0;
  logic cb_i = 1'b0;
  logic imp_ready_o, dll_locked_o, upd_ok_o, single_clk_o;

  int checks = 0;
  int errors = 0;
  int cal_m, dll_m, idle_m;
  bit upd_m;
  bit single_m;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sram_rdy_seq #(.CAL_CYCLES(CAL), .LOCK_CYCLES(LCK), .TIMEOUT(TO)) dut_i (
    .clk_i, .rst_ni, .k_tick_i, .rd_i, .c_i, .cb_i,
    .imp_ready_o, .dll_locked_o, .upd_ok_o, .single_clk_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " R2/R3 imp_ready"}, imp_ready_o, 1'(cal_m == CAL));
    chk({tag, " R5/R6 dll_locked"}, dll_locked_o, 1'(dll_m == LCK));
    chk({tag, " R4 upd_ok"}, upd_ok_o, upd_m);
    chk({tag, " R7 single"}, single_clk_o, single_m);
  endtask

  // one reference cycle: drive on negedge, update model, check after edge
  task automatic cyc(input bit t, input bit r, input string tag);
    bit lost_prev;
    @(negedge clk_i);
    k_tick_i = t;
    rd_i = r;
    lost_prev = (idle_m == TO);
    if (t && !r && cal_m < CAL) cal_m++;
    if (t) idle_m = 0; else if (idle_m < TO) idle_m++;
    if (lost_prev && !t) dll_m = 0; else if (t && dll_m < LCK) dll_m++;
    upd_m = t && !r;
    @(posedge clk_i);
    #2;
    chk_all(tag);
  endtask

  task automatic do_reset(input bit c, input bit cb);
    @(negedge clk_i);
    rst_ni = 1'b0;
    k_tick_i = 1'b0;
    rd_i = 1'b0;
    c_i = c;
    cb_i = cb;
    #1;
    // R1: flags low during reset
    chk("R1 imp_ready in reset", imp_ready_o, 1'b0);
    chk("R1 dll_locked in reset", dll_locked_o, 1'b0);
    chk("R1 upd_ok in reset", upd_ok_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cal_m = 0; dll_m = 0; idle_m = 0; upd_m = 1'b0;
    single_m = c && cb;
    cyc(1'b0, 1'b0, "R1 R8 post-reset");
  endtask

  initial begin
    // R7: both high selects single-clock mode; later changes are ignored
    do_reset(1'b1, 1'b1);
    chk("R7 single latched", single_clk_o, 1'b1);
    c_i = 1'b0;
    // R2: continuous non-read cycles calibrate; R5 lock with them
    for (int i = 0; i < CAL + 2; i++) cyc(1'b1, 1'b0, "sweep A");
    chk("R2 ready after full count", imp_ready_o, 1'b1);
    chk("R5 locked", dll_locked_o, 1'b1);
    chk("R7 mode unchanged after c_i drop", single_clk_o, 1'b1);
    // R3: reads after ready do not clear it
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, "R3 reads after ready");
    chk("R3 ready kept", imp_ready_o, 1'b1);

    // R8: reset resamples mode (dual now), R3 reads pause calibration
    do_reset(1'b1, 1'b0);
    cb_i = 1'b1;
    for (int i = 0; i < CAL - 1; i++) begin
      cyc(1'b1, 1'b0, "sweep B");
      cyc(1'b1, 1'b1, "sweep B read");
    end
    chk("R3 read cycles not counted", imp_ready_o, 1'b0);
    chk("R8 mode resampled dual", single_clk_o, 1'b0);
    cyc(1'b1, 1'b0, "R2 last non-read");
    chk("R2 ready on final non-read", imp_ready_o, 1'b1);

    // R9: gaps below timeout keep lock
    for (int g = 0; g < TO; g++)
      for (int n = 0; n < 3; n++) begin
        cyc(1'b1, n[0], "R9 gap tick");
        for (int k = 0; k < g; k++) cyc(1'b0, 1'b0, "R9 gap idle");
      end
    chk("R9 lock held across short gaps", dll_locked_o, 1'b1);

    // R6: stopped clock longer than timeout, then relock
    for (int i = 0; i < TO + 3; i++) cyc(1'b0, 1'b0, "R6 stopped");
    chk("R6 lock lost", dll_locked_o, 1'b0);
    chk("R2 ready kept across clock loss", imp_ready_o, 1'b1);
    for (int i = 0; i < LCK - 1; i++) cyc(1'b1, 1'b1, "R6 relock");
    chk("R6 not yet relocked", dll_locked_o, 1'b0);
    cyc(1'b1, 1'b0, "R6 relock final");
    chk("R6 relocked", dll_locked_o, 1'b1);

    // mixed pseudo-random sweep against the model (R2..R6, R9)
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 3000; i++)
      cyc(1'($urandom_range(0, 2) != 0 || (i % 50) < 20 ? ($urandom_range(0, 3) != 0) : 0),
          1'($urandom_range(0, 1)), "random");
    done = 1'b1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 100000) begin
      @(posedge clk_i);
      cnt++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule